// File: doc/BRIEF.md
# Tiered Heartbeat Reset Supervisor

This block watches a set of heartbeat inputs inside a chip. Typical sources are a health line toggled by processor software and activity lines from fabric hardware engines. Any level change on an input counts as a heartbeat. Each input has its own silence limit, given in clock cycles. When an input stays quiet for that long, the block first tries to fix the problem locally. It pulses a reset to that element only, then waits through a grace window before it watches the input again.

The block also drives one outward-facing heartbeat to an external watchdog device. This line toggles at a fixed divided rate while every element is healthy or still being recovered. An element that keeps failing after its allowed number of back-to-back local resets is marked dead. From that point the outward heartbeat freezes, so the external watchdog can restart the whole device. The block reports the condition of each element as a two-bit code.

Top module: `hb_supervisor`

## Requirements
- R1: While rst_n is low and right after it is released: every elem_rst bit is 0, every status field is 00 and ext_hb is 0.
- R2: Any level change on hb_in[i] restarts the silence count of source i. A source that changes level at intervals shorter than its limit never receives a reset and keeps status 00.
- R3: Let T be the limit for source i (tmo_cfg bits [16*i+15:16*i], T >= 1). If hb_in[i] does not change for T consecutive rising clock edges while being watched, elem_rst[i] is high after the T-th edge.
- R4: Each local reset keeps elem_rst[i] high for exactly PULSE_LEN consecutive cycles.
- R5: After the pulse, source i is not watched for GRACE_LEN cycles. The next possible timeout comes T edges after that window ends.
- R6: Status of source i is elem_state[2*i+1:2*i]. The code is 00 for healthy (watching), 01 for recovering (in the pulse or the grace window) and 10 for failed. The code 11 never appears.
- R7: A heartbeat seen while watching clears the count of consecutive attempts. A timeout that occurs after MAX_TRIES attempts with no heartbeat in between sets the status to 10 instead of pulsing. A failed source never has elem_rst high.
- R8: A failed status stays 10, whatever hb_in does, until rst_n is asserted.
- R9: While no source is failed, ext_hb changes level every EXT_DIV cycles. The first change comes after the EXT_DIV-th edge following reset.
- R10: Once any source is failed, ext_hb holds its level.
- R11: Sources are independent. A timeout on one source leaves the reset and status of every other source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_in | input | N_SRC | Heartbeat lines, one per element; any level change is a beat |
| tmo_cfg | input | N_SRC*CNT_W | Per-source silence limit in cycles, source i at slice i |
| elem_rst | output | N_SRC | Local reset pulse to each element |
| elem_state | output | 2*N_SRC | Two-bit status per element (00 ok, 01 recovering, 10 failed) |
| ext_hb | output | 1 | Divided heartbeat to the external watchdog |

## Verification
The properties assume a few things about the inputs. tmo_cfg is held steady and non-zero while rst_n is high. Heartbeat lines change level in step with the clock, and every run begins with a reset. The bench meets these conditions by loading the limits before reset is released and never changing them afterwards. It changes the heartbeat lines only one time unit after a rising edge, from a single driver that toggles the selected lines every four cycles. On that basis the pulse length, the freeze of ext_hb and its exact period can be checked with counters that start at reset.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;

    // Status code reported per element
    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_RECOV = 2'b01,
        ST_FAIL  = 2'b10
    } hb_stat_e;

    // Internal phase of one channel monitor
    typedef enum logic [1:0] {
        PH_WATCH = 2'b00,
        PH_PULSE = 2'b01,
        PH_GRACE = 2'b10,
        PH_DEAD  = 2'b11
    } hb_phase_e;

endpackage

// File: rtl/hb_channel.sv
module hb_channel
    import hb_sup_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 4,
    parameter int GRACE_LEN = 10,
    parameter int MAX_TRIES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_i,
    input  logic [CNT_W-1:0] tmo_i,
    output logic             rst_o,
    output hb_stat_e         stat_o
);
    localparam int PG_MAX = (PULSE_LEN > GRACE_LEN) ? PULSE_LEN : GRACE_LEN;
    localparam int PG_W   = $clog2(PG_MAX + 1);
    localparam int TIM_W  = (CNT_W > PG_W) ? CNT_W : PG_W;
    localparam int TRY_W  = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        hb_phase_e        phase;
        logic [TIM_W-1:0] cnt;
        logic [TRY_W-1:0] tries;
        logic             prev;
    } chan_s;

    chan_s            ch_d, ch_q;
    logic             beat;
    logic [TIM_W:0]   cnt_inc;
    logic [TIM_W:0]   tmo_ext;

    always_comb begin
        ch_d      = ch_q;
        ch_d.prev = hb_i;
        beat      = hb_i ^ ch_q.prev;
        cnt_inc   = {1'b0, ch_q.cnt} + (TIM_W+1)'(1);
        tmo_ext   = (TIM_W+1)'(tmo_i);
        case (ch_q.phase)
            PH_WATCH: begin
                if (beat) begin
                    ch_d.cnt   = '0;
                    ch_d.tries = '0;
                end else if (cnt_inc >= tmo_ext) begin
                    ch_d.cnt = '0;
                    if (ch_q.tries == TRY_W'(MAX_TRIES)) begin
                        ch_d.phase = PH_DEAD;
                    end else begin
                        ch_d.phase = PH_PULSE;
                        ch_d.tries = ch_q.tries + TRY_W'(1);
                    end
                end else begin
                    ch_d.cnt = cnt_inc[TIM_W-1:0];
                end
            end
            PH_PULSE: begin
                if (ch_q.cnt == TIM_W'(PULSE_LEN - 1)) begin
                    ch_d.phase = PH_GRACE;
                    ch_d.cnt   = '0;
                end else begin
                    ch_d.cnt = cnt_inc[TIM_W-1:0];
                end
            end
            PH_GRACE: begin
                if (ch_q.cnt == TIM_W'(GRACE_LEN - 1)) begin
                    ch_d.phase = PH_WATCH;
                    ch_d.cnt   = '0;
                end else begin
                    ch_d.cnt = cnt_inc[TIM_W-1:0];
                end
            end
            PH_DEAD: begin
                ch_d.phase = PH_DEAD;
            end
            default: ch_d.phase = PH_DEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '{phase: PH_WATCH, cnt: '0, tries: '0, prev: 1'b0};
        end else begin
            ch_q <= ch_d;
        end
    end

    always_comb begin
        rst_o = (ch_q.phase == PH_PULSE);
        case (ch_q.phase)
            PH_WATCH:           stat_o = ST_OK;
            PH_PULSE, PH_GRACE: stat_o = ST_RECOV;
            default:            stat_o = ST_FAIL;
        endcase
    end

endmodule

// File: rtl/hb_ext_beat.sv
module hb_ext_beat #(
    parameter int EXT_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    output logic beat_o
);
    localparam int DIV_W = (EXT_DIV > 2) ? $clog2(EXT_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             beat;
    } ext_s;

    ext_s ex_d, ex_q;

    always_comb begin
        ex_d = ex_q;
        if (!halt_i) begin
            if (ex_q.cnt == DIV_W'(EXT_DIV - 1)) begin
                ex_d.cnt  = '0;
                ex_d.beat = ~ex_q.beat;
            end else begin
                ex_d.cnt = ex_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_q <= '{cnt: '0, beat: 1'b0};
        end else begin
            ex_q <= ex_d;
        end
    end

    assign beat_o = ex_q.beat;

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
    import hb_sup_pkg::*;
#(
    parameter int N_SRC     = 4,
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 4,
    parameter int GRACE_LEN = 10,
    parameter int MAX_TRIES = 2,
    parameter int EXT_DIV   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       hb_in,
    input  logic [N_SRC*CNT_W-1:0] tmo_cfg,
    output logic [N_SRC-1:0]       elem_rst,
    output logic [2*N_SRC-1:0]     elem_state,
    output logic                   ext_hb
);
    hb_stat_e         stat [N_SRC];
    logic [N_SRC-1:0] dead;
    logic             any_dead;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chan
        hb_channel #(
            .CNT_W     (CNT_W),
            .PULSE_LEN (PULSE_LEN),
            .GRACE_LEN (GRACE_LEN),
            .MAX_TRIES (MAX_TRIES)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .hb_i   (hb_in[g]),
            .tmo_i  (tmo_cfg[g*CNT_W +: CNT_W]),
            .rst_o  (elem_rst[g]),
            .stat_o (stat[g])
        );
        assign elem_state[2*g +: 2] = stat[g];
        assign dead[g]              = (stat[g] == ST_FAIL);
    end

    assign any_dead = |dead;

    hb_ext_beat #(
        .EXT_DIV (EXT_DIV)
    ) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt_i (any_dead),
        .beat_o (ext_hb)
    );

endmodule

// File: rtl/hb_supervisor_chk.sv
module hb_supervisor_chk #(
    parameter int N_SRC     = 4,
    parameter int PULSE_LEN = 4,
    parameter int EXT_DIV   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_SRC-1:0]    elem_rst,
    input logic [2*N_SRC-1:0]  elem_state,
    input logic                ext_hb
);
    logic [N_SRC-1:0] failed;
    logic             ext_p_q;
    int unsigned      gap_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_fail
        assign failed[g] = (elem_state[2*g +: 2] == 2'b10);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_p_q <= 1'b0;
            gap_q   <= 0;
        end else begin
            ext_p_q <= ext_hb;
            if (ext_hb != ext_p_q)       gap_q <= 1;
            else if (gap_q < 32'hFFFF)   gap_q <= gap_q + 1;
        end
    end

    assert_beat_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hb != ext_p_q) |-> (gap_q == EXT_DIV));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|failed) |=> $stable(ext_hb));

    for (genvar g = 0; g < N_SRC; g++) begin : g_props
        logic        rp_q;
        int unsigned run_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rp_q  <= 1'b0;
                run_q <= 0;
            end else begin
                rp_q  <= elem_rst[g];
                run_q <= elem_rst[g] ? run_q + 1 : 0;
            end
        end

        assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rp_q && !elem_rst[g]) |-> (run_q == PULSE_LEN));

        assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            elem_rst[g] |-> (run_q < PULSE_LEN));

        assert_rst_recov_R6: assert property (@(posedge clk) disable iff (!rst_n)
            elem_rst[g] |-> (elem_state[2*g +: 2] == 2'b01));

        assert_code_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
            elem_state[2*g +: 2] != 2'b11);

        assert_dead_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            failed[g] |-> !elem_rst[g]);

        assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            failed[g] |=> failed[g]);
    end

endmodule

bind hb_supervisor hb_supervisor_chk #(
    .N_SRC     (N_SRC),
    .PULSE_LEN (PULSE_LEN),
    .EXT_DIV   (EXT_DIV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .elem_rst   (elem_rst),
    .elem_state (elem_state),
    .ext_hb     (ext_hb)
);

// File: tb/sim_hb_supervisor.sv
`timescale 1ns/1ps
module sim_hb_supervisor;
    localparam int N   = 4;
    localparam int CW  = 16;
    localparam int PL  = 4;
    localparam int GL  = 10;
    localparam int MT  = 2;
    localparam int DIV = 8;
    localparam int TMO = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    hb;
    logic [N*CW-1:0] tmo_cfg;
    logic [N-1:0]    elem_rst;
    logic [2*N-1:0]  elem_state;
    logic            ext_hb;

    logic [N-1:0]    alive = '0;
    logic [7:0]      tick;
    logic [N-1:0]    seen_rst = '0;
    int              n_run = 0;
    int              n_fail = 0;
    int              flips = 0;
    logic            ext_last = 1'b0;
    bit              done = 1'b0;

    always #5 clk = ~clk;

    hb_supervisor #(
        .N_SRC(N), .CNT_W(CW), .PULSE_LEN(PL), .GRACE_LEN(GL),
        .MAX_TRIES(MT), .EXT_DIV(DIV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .hb_in(hb), .tmo_cfg(tmo_cfg),
        .elem_rst(elem_rst), .elem_state(elem_state), .ext_hb(ext_hb)
    );

    // single heartbeat driver: changes lines 1 ns after a rising edge
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            hb   <= '0;
            tick <= '0;
        end else begin
            tick <= tick + 8'd1;
            for (int i = 0; i < N; i++)
                if (alive[i] && tick[1:0] == 2'b00) hb[i] <= ~hb[i];
        end
    end

    always @(negedge clk) seen_rst <= seen_rst | elem_rst;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int st(input int i);
        return int'(elem_state[2*i +: 2]);
    endfunction

    task automatic adv(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (ext_hb != ext_last) flips++;
            ext_last = ext_hb;
        end
    endtask

    task automatic do_reset(input logic [N-1:0] live);
        @(negedge clk);
        rst_n = 1'b0;
        alive = live;
        for (int i = 0; i < N; i++) tmo_cfg[i*CW +: CW] = CW'(TMO);
        adv(3);
        seen_rst = '0;
        rst_n    = 1'b1;
        flips    = 0;
        ext_last = ext_hb;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        adv(2);
        chk(elem_rst == '0 && elem_state == '0 && ext_hb == 1'b0, "R1 during reset",
            int'({elem_rst, elem_state, ext_hb}), 0);
        do_reset('1);
        chk(elem_rst == '0 && elem_state == '0 && ext_hb == 1'b0, "R1 after release",
            int'({elem_rst, elem_state, ext_hb}), 0);
    endtask

    task automatic t_ext_rate();
        do_reset('1);
        adv(DIV - 1);
        chk(ext_hb == 1'b0, "R9 before first toggle", int'(ext_hb), 0);
        adv(1);
        chk(ext_hb == 1'b1, "R9 first toggle", int'(ext_hb), 1);
        adv(DIV);
        chk(ext_hb == 1'b0, "R9 second toggle", int'(ext_hb), 0);
    endtask

    task automatic t_keepalive();
        do_reset('1);
        adv(200);
        chk(seen_rst == '0, "R2 no reset while beating", int'(seen_rst), 0);
        chk(elem_state == '0, "R2 all healthy", int'(elem_state), 0);
        chk(flips == 25, "R9 period while healthy", flips, 25);
    endtask

    task automatic t_chain();
        do_reset(4'b1110);
        adv(TMO - 1);
        chk(elem_rst[0] == 1'b0 && st(0) == 0, "R3 before limit", st(0), 0);
        adv(1);
        chk(elem_rst[0] == 1'b1, "R3 reset at limit", int'(elem_rst[0]), 1);
        chk(st(0) == 1, "R6 recovering code", st(0), 1);
        adv(PL - 1);
        chk(elem_rst[0] == 1'b1, "R4 last pulse cycle", int'(elem_rst[0]), 1);
        adv(1);
        chk(elem_rst[0] == 1'b0 && st(0) == 1, "R4 pulse ended, grace", st(0), 1);
        adv(GL + TMO - 1);
        chk(elem_rst[0] == 1'b0 && st(0) == 0, "R5 no timeout during grace", st(0), 0);
        adv(1);
        chk(elem_rst[0] == 1'b1, "R5 second attempt", int'(elem_rst[0]), 1);
        adv(PL + GL + TMO - 1);
        chk(st(0) == 0, "R7 watching before final timeout", st(0), 0);
        adv(1);
        chk(st(0) == 2 && elem_rst[0] == 1'b0, "R7 failed after tries", st(0), 2);
        chk(flips == 11, "R9 beat kept while recovering", flips, 11);
        flips = 0;
        seen_rst[0] = 1'b0;
        adv(40);
        chk(flips == 0, "R10 beat frozen", flips, 0);
        chk(seen_rst[0] == 1'b0, "R7 no pulse when failed", int'(seen_rst[0]), 0);
        chk(seen_rst[3:1] == '0 && elem_state[7:2] == '0, "R11 others untouched",
            int'({seen_rst[3:1], elem_state[7:2]}), 0);
        alive = 4'b1111;
        adv(50);
        chk(st(0) == 2, "R8 failed stays despite beats", st(0), 2);
        chk(flips == 0, "R10 still frozen", flips, 0);
        do_reset('1);
        chk(st(0) == 0, "R8 cleared by reset", st(0), 0);
    endtask

    task automatic t_retry_clear();
        do_reset(4'b1110);
        adv(40);
        chk(st(0) == 0, "R7 watching after first attempt", st(0), 0);
        alive[0] = 1'b1;
        adv(8);
        alive[0] = 1'b0;
        adv(66);
        chk(st(0) != 2, "R7 attempts cleared by beat", st(0), 1);
        adv(40);
        chk(st(0) == 2, "R7 fails after fresh attempts", st(0), 2);
    endtask

    initial begin
        hb = '0;
        tick = '0;
        tmo_cfg = '0;
        for (int i = 0; i < N; i++) tmo_cfg[i*CW +: CW] = CW'(TMO);
        t_reset_state();
        t_ext_rate();
        t_keepalive();
        t_chain();
        t_retry_clear();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule